// File: doc/BRIEF.md
# Cascadable 32-Source Interrupt Event Latch

This block gathers up to 32 interrupt request lines into one register-mapped interrupt unit. It brings every line through a two-flop synchronizer. It turns a rising edge on an enabled line into a sticky pending bit. It combines the pending, enabled bits into one active-high request output. Software works through a small 32-bit register port with an address, a write enable and write data. The read data is combinational on the address. Pending bits are acknowledged by writing ones to a clear register.

Next to the pending register, software can also read the synchronized current level of every line. Clearing does not affect this level view. A driver that re-enables a source can therefore see that the line is still asserted and treat it as pending again, even though no new edge arrived. The request output is registered, so two copies can be chained: one copy's output feeds an input of another copy. A parent that needs a level-type source can use the level view for that input.

Top module: `irq_event_ctl`

## Requirements
- R1: While and after reset, the pending, enable and level registers read zero and `irq_out` is low.
- R2: Registers sit at byte offsets 0x20 (pending), 0x24 (enable), 0x28 (clear) and 0x2c (level). Bit n of each belongs to source n. Reads of the clear offset and of any other offset return zero.
- R3: A rising edge on an enabled source sets its pending bit. The bit then stays set after the line falls, until it is cleared.
- R4: A rising edge on a source whose enable bit is 0 sets nothing. Enabling that source later, while its line is still high, also sets nothing.
- R5: Writing the clear register clears exactly the pending bits written as 1 and leaves the others. Writing 0xFFFFFFFF clears all of them.
- R6: If a latching edge and a clear of the same bit take effect in the same cycle, the bit ends up set.
- R7: The enable register reads back the last full word written to it. Writing 0 masks every source: `irq_out` drops while the pending bits are kept.
- R8: The level register shows each line's synchronized current state, whether or not its pending bit has been cleared.
- R9: `irq_out` is the OR of (pending AND enable), registered: it changes one clock after the register values that cause it.
- R10: Writes to the pending and level offsets change no state.
- R11: A line change is visible in the level register after the second clock edge. A rising edge sets its pending bit at the third edge and `irq_out` at the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC (32) | Asynchronous interrupt request lines |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Combined active-high request |

## Verification
The bench drives a line high exactly one synchronizer latency before a clear of the same bit commits. A design that let the clear win would lose an interrupt that arrived during the acknowledge. It raises a line while that line is masked and then unmasks it, to catch a design that latches on level instead of edge. It counts edges to confirm the two-stage synchronizer and the registered output. A design with one flop too many or too few would show the level, the pending bit or `irq_out` one cycle off. Random patterns of line changes, enable words, partial clears and stray writes to the read-only offsets then check that pending bits are neither dropped nor created by unrelated traffic.

// File: rtl/irq_event_pkg.sv
package irq_event_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int SRC_MAX = 32;

    localparam logic [ADDR_W-1:0] OFF_PEND  = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_EN    = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_CLR   = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_LEVEL = 8'h2c;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_EN,
        SEL_CLR,
        SEL_LEVEL
    } reg_sel_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
        case (a)
            OFF_PEND:  return SEL_PEND;
            OFF_EN:    return SEL_EN;
            OFF_CLR:   return SEL_CLR;
            OFF_LEVEL: return SEL_LEVEL;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_sync_chain.sv
module irq_sync_chain #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/irq_event_bank.sv
module irq_event_bank #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] level,
    input  logic [NUM_SRC-1:0] enable,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] pend
);
    logic [NUM_SRC-1:0] prev_q;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] set_vec;

    assign rise    = level & ~prev_q;
    assign set_vec = rise & enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend   <= '0;
        end else begin
            prev_q <= level;
            pend   <= (pend & ~clr) | set_vec;
        end
    end

    // R6: a latching edge always lands, even against a clear
    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec)));

    // R5: cleared bits with no concurrent edge go to zero
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        ((clr & ~set_vec) != '0) |=> ((pend & $past(clr & ~set_vec)) == '0));

    // R3: with no edge and no clear, pending state holds
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (clr == '0 && set_vec == '0) |=> $stable(pend));
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_event_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           req,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] level,
    output logic [NUM_SRC-1:0] enable,
    output logic [NUM_SRC-1:0] clr,
    output logic [DATA_W-1:0]  rdata
);
    reg_sel_e sel;

    assign sel = decode_addr(req.addr);
    assign clr = (req.we && sel == SEL_CLR) ? req.wdata[NUM_SRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
        end else if (req.we && sel == SEL_EN) begin
            enable <= req.wdata[NUM_SRC-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_PEND:  rdata[NUM_SRC-1:0] = pend;
            SEL_EN:    rdata[NUM_SRC-1:0] = enable;
            SEL_LEVEL: rdata[NUM_SRC-1:0] = level;
            default:   rdata = '0;
        endcase
    end

    // R2: clear and unmapped offsets read as zero
    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE || sel == SEL_CLR) |-> (rdata == '0));

    // R7: enable takes the whole written word
    p_enable_write_r7: assert property (@(posedge clk) disable iff (rst)
        (req.we && sel == SEL_EN) |=> (enable == $past(req.wdata[NUM_SRC-1:0])));

    // R10: enable is untouched by writes elsewhere
    p_enable_keep_r10: assert property (@(posedge clk) disable iff (rst)
        !(req.we && sel == SEL_EN) |=> $stable(enable));
endmodule

// File: rtl/irq_event_ctl.sv
module irq_event_ctl
    import irq_event_pkg::*;
#(
    parameter int NUM_SRC     = SRC_MAX,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_out
);
    logic [NUM_SRC-1:0] level;
    logic [NUM_SRC-1:0] enable;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] pend;
    bus_req_t           req;

    assign req = '{we: reg_we, addr: reg_addr, wdata: reg_wdata};

    irq_sync_chain #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (src_in),
        .dout (level)
    );

    irq_event_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .level  (level),
        .enable (enable),
        .clr    (clr),
        .pend   (pend)
    );

    irq_reg_port #(.NUM_SRC(NUM_SRC)) u_port (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .pend   (pend),
        .level  (level),
        .enable (enable),
        .clr    (clr),
        .rdata  (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_out <= 1'b0;
        end else begin
            irq_out <= |(pend & enable);
        end
    end

    // R7: a fully masked controller raises no request
    p_masked_out_r7: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |=> !irq_out);

    // R9: any enabled pending source raises the request next cycle
    p_out_follows_r9: assert property (@(posedge clk) disable iff (rst)
        ((pend & enable) != '0) |=> irq_out);
endmodule

// File: tb/irq_event_ctl_tb.sv
module irq_event_ctl_tb;
    localparam logic [7:0] A_PEND = 8'h20, A_EN = 8'h24, A_CLR = 8'h28, A_LVL = 8'h2c;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_in = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_in = '0, m_pend = '0, m_en = '0;

    always #10 clk = ~clk;

    irq_event_ctl u_dut (
        .clk(clk), .rst(rst), .src_in(src_in), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    function automatic logic [31:0] edge_set(logic [31:0] oldv, logic [31:0] newv, logic [31:0] en);
        return newv & ~oldv & en;
    endfunction

    function automatic logic exp_irq(logic [31:0] p, logic [31:0] en);
        return |(p & en);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_in(logic [31:0] v);
        m_pend = m_pend | edge_set(m_in, v, m_en);
        m_in = v;
        src_in = v;
    endtask

    task automatic check_all(string tag);
        logic [31:0] d;
        rd(A_PEND, d); chk({tag, " pend"}, d, m_pend);
        rd(A_EN, d);   chk({tag, " en"}, d, m_en);
        rd(A_LVL, d);  chk({tag, " level"}, d, m_in);
        chk({tag, " irq_out"}, {31'b0, irq_out}, {31'b0, exp_irq(m_pend, m_en)});
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        idle(3);
        // R1: reset state
        check_all("R1 reset");
        @(negedge clk); rst = 1'b0;
        idle(1);
        check_all("R1 after reset");

        // R7: enable readback
        wr(A_EN, 32'hFFFF_FFFF); m_en = 32'hFFFF_FFFF;
        rd(A_EN, d); chk("R7 enable readback", d, 32'hFFFF_FFFF);

        // R11 / R9: latency of level, pending and output
        @(negedge clk);
        drive_in(32'h0000_0080);
        @(negedge clk);
        rd(A_LVL, d);  chk("R11 level after 1 edge", d, 32'h0);
        rd(A_PEND, d); chk("R11 pend after 1 edge", d, 32'h0);
        @(negedge clk);
        rd(A_LVL, d);  chk("R11 level after 2 edges", d, 32'h80);
        rd(A_PEND, d); chk("R11 pend after 2 edges", d, 32'h0);
        @(negedge clk);
        rd(A_PEND, d); chk("R11 pend after 3 edges", d, 32'h80);
        chk("R9 irq_out after 3 edges", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        chk("R9 irq_out after 4 edges", {31'b0, irq_out}, 32'h1);

        // R2: clear and unmapped offsets read zero
        rd(8'h00, d); chk("R2 read 0x00", d, 32'h0);
        rd(8'h1c, d); chk("R2 read 0x1c", d, 32'h0);
        rd(8'h21, d); chk("R2 read 0x21", d, 32'h0);
        rd(8'h30, d); chk("R2 read 0x30", d, 32'h0);
        rd(A_CLR, d); chk("R2 read clear offset", d, 32'h0);

        // R3: pending stays after line falls
        drive_in(32'h0); idle(3);
        check_all("R3 latched after fall");

        // R8 / R5: level independent of clear; clear all
        drive_in(32'h0000_0200); idle(4);
        wr(A_CLR, 32'hFFFF_FFFF); m_pend = '0;
        idle(1);
        check_all("R5 R8 clear all, level held");

        // R5: partial clear
        drive_in(32'h0000_F200); idle(4);
        wr(A_CLR, 32'h0000_5000); m_pend &= ~32'h0000_5000;
        idle(1);
        check_all("R5 partial clear");
        drive_in(32'h0); idle(3);
        wr(A_CLR, 32'hFFFF_FFFF); m_pend = '0; idle(1);

        // R4: edge while masked is not latched, later enable does not latch
        wr(A_EN, ~32'h0000_1000); m_en = ~32'h0000_1000;
        drive_in(32'h0000_1000); idle(4);
        check_all("R4 masked edge");
        wr(A_EN, 32'hFFFF_FFFF); m_en = 32'hFFFF_FFFF;
        idle(3);
        check_all("R4 enable with line high");
        drive_in(32'h0); idle(3);

        // R6: set and clear of the same bit in the same cycle
        @(negedge clk);
        drive_in(32'h0000_0008);
        @(negedge clk);
        wr(A_CLR, 32'h0000_0008);
        idle(1);
        rd(A_PEND, d); chk("R6 set wins over clear", d & 32'h8, 32'h8);
        wr(A_CLR, 32'h0000_0008); m_pend &= ~32'h8;
        idle(1);
        check_all("R6 later clear");

        // R7: mask all keeps pending, drops output
        drive_in(32'h0000_0408); idle(4);
        wr(A_EN, 32'h0); m_en = '0;
        idle(2);
        check_all("R7 mask all");

        // R10: writes to read-only offsets
        wr(A_PEND, 32'h0); wr(A_LVL, 32'hFFFF_FFFF);
        idle(1);
        check_all("R10 ignored writes");
        wr(A_EN, 32'hFFFF_FFFF); m_en = 32'hFFFF_FFFF; idle(2);
        check_all("R9 re-enable");

        // Random traffic
        for (int i = 0; i < 200; i++) begin
            int op;
            op = int'($urandom % 4);
            case (op)
                0: begin @(negedge clk); drive_in($urandom); idle(4); end
                1: begin d = $urandom; wr(A_EN, d); m_en = d; idle(2); end
                2: begin d = $urandom; wr(A_CLR, d); m_pend &= ~d; idle(2); end
                default: begin
                    wr(($urandom % 2) ? A_PEND : A_LVL, $urandom); idle(2);
                end
            endcase
            check_all("R3 R5 R7 R10 random");
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule